// File: doc/BRIEF.md
# Symmetric Low-Bit Pixel Embedder

This block hides a message in a stream of 8-bit grayscale pixels. While the enable is high it takes one pixel per clock. It nudges each pixel so that the modulo-2^m sum of its m low bits and the m low bits of the previous output pixel equals the current message segment. The number of bits per pixel, m, is selectable from 1 to 4.

A pixel may move up or down by less than 2^m. When the correction pushes the value past 255 or below 0, the value is folded back by 2^m. Values near the ends of the range therefore change in both directions, as values in the middle do. Plain low-bit overwriting changes values in one direction only.

A receiver recovers each segment by adding the low m bits of two consecutive stego pixels modulo 2^m. The first pixel of every enabled run carries no message and only seeds the chain.

Top module: `stego_lsb_embed`

## Requirements
- R1: While reset is asserted and after its release, `pix_out` is 0 and `pix_vld` is 0 until the first enabled pixel is registered.
- R2: `pix_vld` equals the value `en` had at the previous rising clock edge. The output pixel for an input appears one clock after that input is sampled with `en` high.
- R3: The first pixel sampled after `en` rises is output unchanged, and its low bits seed the chain.
- R4: For every later pixel of a run, the low m bits of the previous output plus the low m bits of the new output, taken modulo 2^m, equal the message segment.
- R5: Each chained output equals x + e - ((low_m(prev) + low_m(x)) mod 2^m), after folding. Its distance from the input pixel is at most 2^m - 1.
- R6: When the corrected value exceeds 255, 2^m is subtracted. For example, with m=1, input 255, previous low bit 1 and segment 1, the output is 254.
- R7: When the corrected value is negative, 2^m is added. For example, with m=1, input 0, previous low bit 1 and segment 0, the output is 1.
- R8: A `m_sel` value of 0, 5, 6 or 7 behaves exactly like `m_sel`=1.
- R9: The segment comes from `msg1` when m=1, from `msg2` when m=2, from `msg3` when m=3 and from `msg4` when m=4. The unselected message inputs have no effect on the output.
- R10: While `en` is low, `pix_out` holds its value and the chain is cleared. The next enabled pixel is treated as a first pixel (R3).
- R11: Changes go in both directions. With m=1 and previous low bit 1, an input of 98 with segment 0 becomes 97, and an input of 199 with segment 1 becomes 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Process one pixel this clock |
| m_sel | input | 3 | Bits per pixel, 1 to 4 |
| pix_in | input | 8 | Cover pixel |
| msg1 | input | 1 | Segment for m=1 |
| msg2 | input | 2 | Segment for m=2 |
| msg3 | input | 3 | Segment for m=3 |
| msg4 | input | 4 | Segment for m=4 |
| pix_out | output | 8 | Stego pixel, registered |
| pix_vld | output | 1 | `pix_out` was updated on the last edge |

## Verification
The only internal state is the stored low bits of the previous output and the run-start flag. A corrupted stored value breaks the R4 sum on the very next chained pixel, one clock after that pixel is sampled. A wrong run-start flag either alters a first pixel or passes a chained pixel through untouched. Either fault shows on `pix_out` in the cycle after the affected input. The bench decodes every chained output pair at the ports and compares it with the segment it drove. It also targets the two fold boundaries, the out-of-range `m_sel` codes and an enable gap.

// File: rtl/stego_lsb_embed.sv
module stego_lsb_embed #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    m_sel,
  input  logic [PW-1:0] pix_in,
  input  logic          msg1,
  input  logic [1:0]    msg2,
  input  logic [2:0]    msg3,
  input  logic [3:0]    msg4,
  output logic [PW-1:0] pix_out,
  output logic          pix_vld
);
  localparam int AW = PW + 2;
  localparam logic signed [AW-1:0] TOP = AW'((1 << PW) - 1);

  logic [3:0] prev_low;
  logic       started;
  logic [2:0] m_eff;
  logic [3:0] mask, seg, sum_low;
  logic signed [AW-1:0] raw, span, folded, delta, lim;
  logic [PW-1:0] nxt;

  assign m_eff   = (m_sel >= 3'd1 && m_sel <= 3'd4) ? m_sel : 3'd1;
  assign mask    = 4'((5'd1 << m_eff) - 5'd1);
  assign sum_low = (prev_low + (pix_in[3:0] & mask)) & mask;

  always_comb begin
    case (m_eff)
      3'd2:    seg = {2'b00, msg2};
      3'd3:    seg = {1'b0, msg3};
      3'd4:    seg = msg4;
      default: seg = {3'b000, msg1};
    endcase
  end

  assign raw    = $signed({2'b00, pix_in}) + $signed({{(AW-4){1'b0}}, seg})
                - $signed({{(AW-4){1'b0}}, sum_low});
  assign span   = $signed({{(AW-4){1'b0}}, mask}) + AW'(1);
  assign folded = (raw > TOP) ? raw - span : (raw < 0) ? raw + span : raw;
  assign nxt    = started ? folded[PW-1:0] : pix_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out  <= '0;
      pix_vld  <= 1'b0;
      prev_low <= '0;
      started  <= 1'b0;
    end else begin
      pix_vld <= en;
      if (en) begin
        pix_out  <= nxt;
        prev_low <= nxt[3:0];
        started  <= 1'b1;
      end else begin
        started  <= 1'b0;
      end
    end
  end

  assign delta = $signed({2'b00, nxt}) - $signed({2'b00, pix_in});
  assign lim   = $signed({{(AW-4){1'b0}}, mask});

  assert_vld_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> pix_vld);
  assert_vld_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pix_vld);
  assert_first_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !started) |=> pix_out == $past(pix_in));
  assert_chain_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && started) |-> ((prev_low + nxt[3:0]) & mask) == seg);
  assert_small_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (delta <= lim && delta >= -lim));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pix_out));
endmodule

// File: tb/stego_lsb_embed_tb_top.sv
`timescale 1ns/1ps
module stego_lsb_embed_tb_top;
  logic clk = 0, rst_n = 0, en = 0;
  logic [2:0] m_sel = 3'd1;
  logic [7:0] pix_in = 0;
  logic msg1 = 0;
  logic [1:0] msg2 = 0;
  logic [2:0] msg3 = 0;
  logic [3:0] msg4 = 0;
  logic [7:0] pix_out;
  logic pix_vld;

  int checks = 0, errors = 0;
  int exp_out = 0;
  int m_prev = 0;
  bit m_started = 0;

  always #10 clk = ~clk;

  stego_lsb_embed dut_i (.clk(clk), .rst_n(rst_n), .en(en), .m_sel(m_sel),
    .pix_in(pix_in), .msg1(msg1), .msg2(msg2), .msg3(msg3), .msg4(msg4),
    .pix_out(pix_out), .pix_vld(pix_vld));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one clock of input, then check outputs at the next falling edge.
  task automatic step(bit e_n, int x, int ms, int s1, int s2, int s3, int s4,
                      string tag, int forced = -1);
    int m, e, md, s, v, prev_before;
    bit chained;
    en = e_n; pix_in = 8'(x); m_sel = 3'(ms);
    msg1 = 1'(s1); msg2 = 2'(s2); msg3 = 3'(s3); msg4 = 4'(s4);
    m = (ms >= 1 && ms <= 4) ? ms : 1;
    md = 1 << m;
    e = (m == 1) ? s1 % 2 : (m == 2) ? s2 % 4 : (m == 3) ? s3 % 8 : s4 % 16;
    chained = e_n && m_started;
    prev_before = m_prev;
    if (e_n) begin
      if (!m_started) v = x;
      else begin
        s = ((m_prev % md) + (x % md)) % md;
        v = x + e - s;
        if (v > 255) v -= md;
        if (v < 0) v += md;
      end
      exp_out = v; m_prev = v; m_started = 1;
    end else m_started = 0;
    @(negedge clk);
    check({tag, " vld R2"}, pix_vld, e_n);
    check({tag, " out"}, pix_out, exp_out);
    if (forced >= 0) check({tag, " literal"}, pix_out, forced);
    if (chained)
      check({tag, " decode R4"}, ((prev_before % md) + (pix_out % md)) % md, e);
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0;
    repeat (3) @(negedge clk);
    check("reset out R1", pix_out, 0);
    check("reset vld R1", pix_vld, 0);
    rst_n = 1;
    @(negedge clk);
    check("post-reset out R1", pix_out, 0);
    check("post-reset vld R1", pix_vld, 0);
  endtask

  task automatic t_idle();
    step(0, 0, 1, 0, 0, 0, 0, "idle R2");
  endtask

  task automatic t_symmetric();
    step(1, 101, 1, 1, 0, 0, 0, "seed R3", 101);
    step(1, 98, 1, 0, 0, 0, 0, "down R11", 97);
    step(1, 199, 1, 1, 0, 0, 0, "up R11", 200);
    step(0, 55, 1, 1, 0, 0, 0, "gap R10", 200);
  endtask

  task automatic t_overflow();
    step(1, 253, 1, 0, 0, 0, 0, "seed R3", 253);
    step(1, 255, 1, 1, 0, 0, 0, "high fold R6", 254);
    step(0, 0, 1, 0, 0, 0, 0, "gap R10");
  endtask

  task automatic t_underflow();
    step(1, 1, 1, 0, 0, 0, 0, "seed R3", 1);
    step(1, 0, 1, 0, 0, 0, 0, "low fold R7", 1);
    step(0, 0, 1, 0, 0, 0, 0, "gap R10");
  endtask

  task automatic t_widths();
    for (int m = 2; m <= 4; m++) begin
      step(1, 17 * m, m, 1, 3, 5, 9, "width seed R3");
      for (int i = 0; i < 40; i++) begin
        int x;
        x = (i * 37 + m * 11) % 256;
        if (i % 5 == 0) x = 255 - (i % 3);
        if (i % 7 == 0) x = i % 3;
        step(1, x, m, i, i * 3, i * 5, i * 7, "width R5 R9");
      end
      step(0, 0, m, 0, 0, 0, 0, "gap R10");
    end
  endtask

  task automatic t_bad_sel();
    int codes[4] = '{0, 5, 6, 7};
    foreach (codes[k]) begin
      step(1, 40 + k, codes[k], 0, 3, 7, 15, "badsel seed R8");
      for (int i = 0; i < 6; i++)
        step(1, (i * 83 + k) % 256, codes[k], i, 3 - (i % 4), i, 15 - i, "badsel R8");
      step(0, 0, codes[k], 0, 0, 0, 0, "gap R10");
    end
  endtask

  task automatic t_restart();
    step(1, 120, 3, 0, 0, 4, 0, "run R3");
    step(1, 121, 3, 0, 0, 6, 0, "run R4");
    step(0, 9, 3, 0, 0, 2, 0, "hold R10");
    step(0, 10, 3, 0, 0, 1, 0, "hold R10");
    step(1, 77, 3, 0, 0, 5, 0, "restart R10", 77);
    step(1, 78, 3, 0, 0, 5, 0, "restart chain R4");
    step(0, 0, 3, 0, 0, 0, 0, "gap R10");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_symmetric();
    t_overflow();
    t_underflow();
    t_widths();
    t_bad_sel();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule